// File: doc/BRIEF.md
# Guarded Configuration Register Write Sequencer

This block is the slave-side control logic for a protected configuration register inside a two-wire serial memory device. The register holds a two-bit watchdog timeout field and a three-bit block-protect field. The bit-level bus logic decodes the wire activity and passes three kinds of event to the block: a start condition, a received byte, and a stop condition. For each received byte the block returns an acknowledge or a not-acknowledge decision.

Software changes the register through a three-step sequence. The first write frame arms a write-enable latch. The second arms a register-write-enable latch, and it works only if the first latch is already set. The third frame carries the new field values. None of these frames has any effect until a stop condition ends it after exactly one data byte.

A field update starts a timed store cycle. The block reports busy while the store runs and refuses its slave address during that time. When the store ends, the new fields are written into the persistent storage register and both latches are cleared. A frame that is interrupted by a new start, or that carries more than one data byte, is discarded and also clears both latches.

Top module: `ctlg_guard`

## Requirements
- R1: After reset the watchdog field is 01, the protect field is 000, both latches are clear, busy is low and no acknowledge is signalled.
- R2: A slave byte is acknowledged only when its bits [7:4] equal 1011 and no store is running. Otherwise it is not acknowledged and the remaining bytes of that frame produce no acknowledge slot. Bit 0 of the slave byte selects read (1) or write (0).
- R3: The 9-bit target address is formed from slave-byte bit 1 as the high bit and the second byte as the low eight bits. Only address 1FFh is acknowledged; any other address is refused and the rest of the frame is ignored.
- R4: The first data byte of a write frame is acknowledged. Every further data byte in the same frame is not acknowledged. `ack_vld` pulses for one cycle in the cycle after each byte event that expects an answer.
- R5: The data byte and the read byte share one layout: [7:6] watchdog, [5:3] protect, [2] reserved, [1] register-write-enable latch, [0] write-enable latch. The read byte always shows the stored fields and the live latch states, with bit 2 reading 0. A data byte whose bit 2 is 1 is ignored.
- R6: A committed data byte with bits [2:0] = 001 sets the write-enable latch.
- R7: A committed data byte with bits [2:0] = 011 sets the register-write-enable latch only when the write-enable latch is already set. Otherwise nothing changes.
- R8: A committed data byte with bits [2:0] = 000 starts a store only when both latches are set. In every other case the fields and latches stay unchanged.
- R9: A data byte takes effect only when a stop condition follows it. Until then the latches and fields stay unchanged.
- R10: A start condition that arrives after the data byte instead of a stop, or a second data byte, discards the frame, leaves the fields unchanged and clears both latches.
- R11: A store holds `busy` high for exactly STORE_CYCLES cycles. The fields change only in the cycle in which `busy` falls, and both latches clear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start condition seen on the bus (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition seen on the bus (one-cycle pulse) |
| ev_byte | input | 1 | A complete byte has been received (one-cycle pulse) |
| rx_byte | input | 8 | Received byte, valid with `ev_byte` |
| ack_vld | output | 1 | The acknowledge decision is valid this cycle |
| ack | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| busy | output | 1 | Store cycle in progress |
| wd_q | output | 2 | Stored watchdog field |
| bp_q | output | 3 | Stored block-protect field |
| rd_byte | output | 8 | Byte returned on a register read |

## Verification
The assertions check the following on every cycle:
- Refused addresses while busy.
- Acknowledge slots that follow a byte event.
- The register-write-enable latch rising only with the write-enable latch already set.
- A store starting only from the fully unlocked state.
- The exact length of each busy window.
- The fields changing only at the end of a store, together with the clearing of the latches.

The bench scenarios cover what depends on the order of bus events:
- The three-step unlock.
- Commands that are deferred until stop.
- Rejected preambles, addresses and reserved-bit commands.
- Frames discarded by a restart or by an extra data byte.
- The read-back layout.

// File: rtl/ctlg_pkg.sv
package ctlg_pkg;

   typedef enum logic [2:0] {
      F_IDLE,
      F_SLV,
      F_ADR,
      F_DAT,
      F_HELD,
      F_DEAD,
      F_RD
   } frame_e;

   typedef struct packed {
      logic [1:0] wd;
      logic [2:0] bp;
   } cfg_t;

   localparam logic [2:0] CMD_STORE = 3'b000;
   localparam logic [2:0] CMD_WEL   = 3'b001;
   localparam logic [2:0] CMD_RWEL  = 3'b011;

endpackage

// File: rtl/ctlg_frame.sv
module ctlg_frame
   import ctlg_pkg::*;
#(
   parameter int              ADDR_W   = 9,
   parameter logic [3:0]      PREAMBLE = 4'b1011,
   parameter logic [ADDR_W-1:0] REG_ADDR = 9'h1FF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start,
   input  logic       ev_stop,
   input  logic       ev_byte,
   input  logic [7:0] rx_byte,
   input  logic       busy,
   output logic       ack_vld,
   output logic       ack,
   output logic       commit,
   output logic       abort,
   output logic [7:0] data_q
);

   localparam int HI_W = ADDR_W - 8;
   localparam int HQ_W = (HI_W > 0) ? HI_W : 1;

   if (ADDR_W < 8 || ADDR_W > 11) begin : g_bad_addr_w
      $error("ctlg_frame: ADDR_W must lie in 8..11");
   end

   frame_e          st;
   logic [HQ_W-1:0] hi_q;
   logic [HQ_W-1:0] slv_hi;
   logic            addr_hit;
   logic            slv_hit;

   if (HI_W == 0) begin : g_flat
      assign slv_hi   = '0;
      assign addr_hit = (rx_byte == REG_ADDR[7:0]);
   end else begin : g_paged
      assign slv_hi   = rx_byte[HI_W:1];
      assign addr_hit = ({hi_q[HI_W-1:0], rx_byte} == REG_ADDR);
   end

   assign slv_hit = (rx_byte[7:4] == PREAMBLE) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= F_IDLE;
         ack_vld <= 1'b0;
         ack     <= 1'b0;
         commit  <= 1'b0;
         abort   <= 1'b0;
         data_q  <= '0;
         hi_q    <= '0;
      end else begin
         ack_vld <= 1'b0;
         ack     <= 1'b0;
         commit  <= 1'b0;
         abort   <= 1'b0;
         if (ev_start) begin
            abort <= (st == F_HELD);
            st    <= F_SLV;
         end else if (ev_stop) begin
            commit <= (st == F_HELD);
            st     <= F_IDLE;
         end else if (ev_byte) begin
            case (st)
               F_SLV: begin
                  ack_vld <= 1'b1;
                  ack     <= slv_hit;
                  hi_q    <= slv_hi;
                  if (!slv_hit)        st <= F_DEAD;
                  else if (rx_byte[0]) st <= F_RD;
                  else                 st <= F_ADR;
               end
               F_ADR: begin
                  ack_vld <= 1'b1;
                  ack     <= addr_hit;
                  st      <= addr_hit ? F_DAT : F_DEAD;
               end
               F_DAT: begin
                  ack_vld <= 1'b1;
                  ack     <= 1'b1;
                  data_q  <= rx_byte;
                  st      <= F_HELD;
               end
               F_HELD: begin
                  ack_vld <= 1'b1;
                  ack     <= 1'b0;
                  abort   <= 1'b1;
                  st      <= F_DEAD;
               end
               default: st <= st;
            endcase
         end
      end
   end

endmodule

// File: rtl/ctlg_latch.sv
module ctlg_latch
   import ctlg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       commit,
   input  logic       abort,
   input  logic [2:0] cmd,
   input  logic       store_done,
   output logic       wel,
   output logic       rwel,
   output logic       store_go
);

   assign store_go = commit && (cmd == CMD_STORE) && wel && rwel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         rwel <= 1'b0;
      end else if (abort || store_done) begin
         wel  <= 1'b0;
         rwel <= 1'b0;
      end else if (commit) begin
         case (cmd)
            CMD_WEL:  wel <= 1'b1;
            CMD_RWEL: if (wel) rwel <= 1'b1;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/ctlg_store.sv
module ctlg_store
   import ctlg_pkg::*;
#(
   parameter int   STORE_CYCLES = 20,
   parameter cfg_t RST_CFG      = 5'b01_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic store_go,
   input  cfg_t new_cfg,
   output logic busy,
   output logic store_done,
   output cfg_t cfg_q
);

   localparam int CNT_W = $clog2(STORE_CYCLES + 1);

   if (STORE_CYCLES < 2) begin : g_bad_cycles
      $error("ctlg_store: STORE_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   cfg_t             pend;

   assign busy       = (cnt != '0);
   assign store_done = (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         pend  <= RST_CFG;
         cfg_q <= RST_CFG;
      end else if (store_go) begin
         cnt  <= CNT_W'(STORE_CYCLES);
         pend <= new_cfg;
      end else if (busy) begin
         cnt <= cnt - CNT_W'(1);
         if (store_done) cfg_q <= pend;
      end
   end

endmodule

// File: rtl/ctlg_guard.sv
module ctlg_guard
   import ctlg_pkg::*;
#(
   parameter int                STORE_CYCLES = 20,
   parameter int                ADDR_W       = 9,
   parameter logic [3:0]        PREAMBLE     = 4'b1011,
   parameter logic [ADDR_W-1:0] REG_ADDR     = 9'h1FF,
   parameter logic [1:0]        RST_WD       = 2'b01,
   parameter logic [2:0]        RST_BP       = 3'b000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start,
   input  logic       ev_stop,
   input  logic       ev_byte,
   input  logic [7:0] rx_byte,
   output logic       ack_vld,
   output logic       ack,
   output logic       busy,
   output logic [1:0] wd_q,
   output logic [2:0] bp_q,
   output logic [7:0] rd_byte
);

   localparam cfg_t RST_CFG = {RST_WD, RST_BP};

   logic       commit, abort, store_go, store_done, wel, rwel;
   logic [7:0] data_q;
   cfg_t       cfg_q;

   ctlg_frame #(
      .ADDR_W  (ADDR_W),
      .PREAMBLE(PREAMBLE),
      .REG_ADDR(REG_ADDR)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_start(ev_start),
      .ev_stop (ev_stop),
      .ev_byte (ev_byte),
      .rx_byte (rx_byte),
      .busy    (busy),
      .ack_vld (ack_vld),
      .ack     (ack),
      .commit  (commit),
      .abort   (abort),
      .data_q  (data_q)
   );

   ctlg_latch u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .abort     (abort),
      .cmd       (data_q[2:0]),
      .store_done(store_done),
      .wel       (wel),
      .rwel      (rwel),
      .store_go  (store_go)
   );

   ctlg_store #(
      .STORE_CYCLES(STORE_CYCLES),
      .RST_CFG     (RST_CFG)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .store_go  (store_go),
      .new_cfg   (cfg_t'(data_q[7:3])),
      .busy      (busy),
      .store_done(store_done),
      .cfg_q     (cfg_q)
   );

   assign wd_q    = cfg_q.wd;
   assign bp_q    = cfg_q.bp;
   assign rd_byte = {cfg_q.wd, cfg_q.bp, 1'b0, rwel, wel};

endmodule

// File: rtl/ctlg_guard_chk.sv
module ctlg_guard_chk #(
   parameter int STORE_CYCLES = 20
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_byte,
   input logic       ack_vld,
   input logic       ack,
   input logic       busy,
   input logic [1:0] wd_q,
   input logic [2:0] bp_q,
   input logic [1:0] lat
);

   localparam int CNT_W = $clog2(STORE_CYCLES + 1);

   logic [CNT_W:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1'b1;
      else           run <= '0;
   end

   a_r2_nack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld && $past(busy)) |-> !ack);

   a_r4_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> $past(ev_byte));

   a_r7_rwel_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat[1]) |-> $past(lat[0]));

   a_r8_store_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(lat) == 2'b11));

   a_r11_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run == (CNT_W+1)'(STORE_CYCLES)));

   a_r11_fields_move_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({wd_q, bp_q}) |-> $fell(busy));

   a_r11_latches_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (lat == 2'b00));

endmodule

bind ctlg_guard ctlg_guard_chk #(.STORE_CYCLES(STORE_CYCLES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ev_byte(ev_byte),
   .ack_vld(ack_vld),
   .ack    (ack),
   .busy   (busy),
   .wd_q   (wd_q),
   .bp_q   (bp_q),
   .lat    (rd_byte[1:0])
);

// File: tb/tb_ctlg_guard.sv
module tb_ctlg_guard;

   localparam int STORE_CYCLES = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_start = 1'b0;
   logic       ev_stop = 1'b0;
   logic       ev_byte = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       ack_vld, ack, busy;
   logic [1:0] wd_q;
   logic [2:0] bp_q;
   logic [7:0] rd_byte;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ctlg_guard #(.STORE_CYCLES(STORE_CYCLES)) dut (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_byte(ev_byte), .rx_byte(rx_byte), .ack_vld(ack_vld), .ack(ack),
      .busy(busy), .wd_q(wd_q), .bp_q(bp_q), .rd_byte(rd_byte)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic do_start();
      @(negedge clk) ev_start = 1'b1;
      @(negedge clk) ev_start = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk) ev_stop = 1'b1;
      @(negedge clk) ev_stop = 1'b0;
      @(negedge clk);
   endtask

   task automatic put_byte(input logic [7:0] b, input logic ev, input logic ea, input string req);
      @(negedge clk) begin ev_byte = 1'b1; rx_byte = b; end
      @(negedge clk) ev_byte = 1'b0;
      check({req, " ack_vld"}, ack_vld, ev);
      if (ev) check({req, " ack"}, ack, ea);
   endtask

   task automatic wr_frame(input logic [7:0] data);
      do_start();
      put_byte(8'hB2, 1'b1, 1'b1, "R2");
      put_byte(8'hFF, 1'b1, 1'b1, "R3");
      put_byte(data, 1'b1, 1'b1, "R4");
      do_stop();
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 100 && busy; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 rd_byte", rd_byte, 8'h40);
      check("R1 wd", wd_q, 2'b01);
      check("R1 bp", bp_q, 3'b000);
      check("R1 busy", busy, 1'b0);
      check("R1 ack_vld", ack_vld, 1'b0);
   endtask

   task automatic t_reject();
      do_start();
      put_byte(8'hA2, 1'b1, 1'b0, "R2 bad preamble");
      put_byte(8'hFF, 1'b0, 1'b0, "R2 frame ignored");
      do_stop();
      do_start();
      put_byte(8'hB2, 1'b1, 1'b1, "R3");
      put_byte(8'hFE, 1'b1, 1'b0, "R3 wrong low address");
      put_byte(8'h01, 1'b0, 1'b0, "R3 frame ignored");
      do_stop();
      do_start();
      put_byte(8'hB0, 1'b1, 1'b1, "R3");
      put_byte(8'hFF, 1'b1, 1'b0, "R3 high bit clear");
      do_stop();
      check("R3 rd_byte unchanged", rd_byte, 8'h40);
   endtask

   task automatic t_ignored();
      wr_frame(8'h00);
      check("R8 store while locked", rd_byte, 8'h40);
      check("R8 no busy", busy, 1'b0);
      wr_frame(8'h03);
      check("R7 rwel without wel", rd_byte, 8'h40);
      wr_frame(8'h05);
      check("R5 reserved bit set ignored", rd_byte, 8'h40);
      wr_frame(8'h01);
      check("R6 wel set", rd_byte, 8'h41);
      wr_frame(8'h00);
      check("R8 store with wel only", rd_byte, 8'h41);
      check("R8 no busy wel only", busy, 1'b0);
      wr_frame(8'h02);
      check("R8 other code ignored", rd_byte, 8'h41);
   endtask

   task automatic t_store();
      int cnt;
      wr_frame(8'h03);
      check("R7 rwel set", rd_byte, 8'h43);
      wr_frame(8'hA8);
      check("R11 busy after stop", busy, 1'b1);
      check("R11 fields held while busy", rd_byte, 8'h43);
      cnt = 0;
      while (busy && cnt < 100) begin
         cnt++;
         @(negedge clk);
      end
      check("R11 busy length", cnt, STORE_CYCLES);
      check("R11 rd_byte after store", rd_byte, 8'hA8);
      check("R11 wd", wd_q, 2'b10);
      check("R11 bp", bp_q, 3'b101);
   endtask

   task automatic t_busy_nack();
      wr_frame(8'h01);
      wr_frame(8'h03);
      check("R7 unlock", rd_byte, 8'hAB);
      wr_frame(8'h70);
      check("R11 busy", busy, 1'b1);
      do_start();
      put_byte(8'hB2, 1'b1, 1'b0, "R2 nack while busy");
      do_stop();
      wait_idle();
      check("R11 second store", rd_byte, 8'h70);
   endtask

   task automatic t_extra_byte();
      wr_frame(8'h01);
      wr_frame(8'h03);
      check("R6 unlock", rd_byte, 8'h73);
      do_start();
      put_byte(8'hB2, 1'b1, 1'b1, "R2");
      put_byte(8'hFF, 1'b1, 1'b1, "R3");
      put_byte(8'hC8, 1'b1, 1'b1, "R4 first data");
      put_byte(8'h11, 1'b1, 1'b0, "R4 second data nack");
      do_stop();
      check("R10 extra byte clears", rd_byte, 8'h70);
      check("R10 no store", busy, 1'b0);
   endtask

   task automatic t_restart();
      wr_frame(8'h01);
      wr_frame(8'h03);
      do_start();
      put_byte(8'hB2, 1'b1, 1'b1, "R2");
      put_byte(8'hFF, 1'b1, 1'b1, "R3");
      put_byte(8'hC8, 1'b1, 1'b1, "R4");
      @(negedge clk);
      check("R9 nothing before stop", rd_byte, 8'h73);
      check("R9 no busy before stop", busy, 1'b0);
      do_start();
      put_byte(8'hB2, 1'b1, 1'b1, "R2 after restart");
      do_stop();
      check("R10 restart clears", rd_byte, 8'h70);
      check("R10 no store", busy, 1'b0);
   endtask

   task automatic t_read();
      wr_frame(8'h01);
      do_start();
      put_byte(8'hB3, 1'b1, 1'b1, "R2 read slave byte");
      check("R5 read layout", rd_byte, 8'h71);
      do_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reject();
      t_ignored();
      t_store();
      t_busy_nack();
      t_extra_byte();
      t_restart();
      t_read();
      finish_run();
   end

endmodule